// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block tracks which of the 32 lanes of one warp are enabled while the warp passes through conditional branches. All enabled lanes run the same instruction together. At each branch the block gets one taken bit per lane, the taken target, the fall-through address and the address where both sides meet again. If all enabled lanes agree, the block only selects the next PC and leaves the mask alone. If they disagree, the block runs the taken side first with only the taken lanes on. It then runs the fall-through side with only the remaining lanes on. At the meeting point it brings back the mask that was in force before the branch.

The sequencer that fetches instructions raises a path-done pulse each time the warp reaches the meeting address of the innermost open branch. A stack of eight entries stores nested divergent branches. Each entry holds the meeting PC, the fall-through PC, the mask still waiting to run, the outer mask and a flag that marks the second side as not yet run. The block counts divergent branches and pulses a flag on each one. It raises a sticky error when a divergent branch arrives while the stack is full.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset, `active_mask` is all ones, `next_pc` is 0, `div_count` is 0 and `diverged` and `ovf_err` are 0. The reset input is asserted asynchronously and released through two flops, so a branch or path-done event is acted on only from the third rising edge after `rst_n` goes high.
- R2: A branch in which every enabled lane has its taken bit set loads `br_target_pc` into `next_pc`. It leaves `active_mask` unchanged, keeps `diverged` at 0 and keeps `div_count` unchanged.
- R3: A branch in which no enabled lane has its taken bit set loads `br_fall_pc` into `next_pc` and leaves the mask unchanged. Taken bits of disabled lanes have no effect on the branch outcome.
- R4: A branch in which the enabled lanes disagree sets `active_mask` to (mask AND taken) and `next_pc` to `br_target_pc`. It pulses `diverged` for one cycle and adds 1 to `div_count`, which wraps at its width. The mask is never all zeros.
- R5: A `path_done` pulse when the innermost entry still has its second side pending sets `active_mask` to (mask at the branch AND NOT taken) and `next_pc` to that branch's fall-through PC. It then marks the second side as run.
- R6: A `path_done` pulse when the innermost entry has no pending side restores that entry's outer mask, sets `next_pc` to its meeting PC and removes the entry.
- R7: Up to 8 divergent branches nest. The entries are undone in last-in, first-out order.
- R8: A divergent branch that arrives while 8 entries are held sets `ovf_err`, which stays set until reset. That branch is not stored, and `active_mask`, `next_pc` and `div_count` keep their values.
- R9: A `path_done` pulse with no entry held has no effect, and neither does a cycle with no event.
- R10: When `br_valid` and `path_done` are high in the same cycle, the branch is acted on and the path-done pulse is dropped.
- R11: Every output changes on the rising edge that samples the event. The result is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch event this cycle |
| br_taken | input | LANES | Per-lane taken vector |
| br_target_pc | input | PC_W | Taken-side address |
| br_fall_pc | input | PC_W | Fall-through address |
| br_reconv_pc | input | PC_W | Address where both sides meet again |
| path_done | input | 1 | Warp reached the innermost meeting address |
| active_mask | output | LANES | Enabled lanes |
| next_pc | output | PC_W | Address to fetch next |
| diverged | output | 1 | One-cycle pulse per stored divergent branch |
| div_count | output | CNT_W | Count of divergent branches, wrapping |
| ovf_err | output | 1 | Sticky: divergent branch refused on a full stack |

## Verification
A wrong stored mask or a stale pending flag stays hidden until the matching path-done pulse. At that point it shows on `active_mask` and `next_pc` in the very next cycle. A wrong stack depth shows either as an early `ovf_err` or as the wrong meeting PC when the nest is undone. The bench runs a behavioural model on a queue and compares all outputs every cycle, so such a fault appears at most one cycle after the event that exposes it. Directed nests with agreeing branches, disagreeing branches, simultaneous events and overflow are followed by a pseudo-random phase.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  // outcome of one branch over the enabled lanes
  typedef enum logic [1:0] {
    BC_ALL_TAKEN = 2'd0,
    BC_NONE_TAKEN = 2'd1,
    BC_SPLIT = 2'd2
  } br_class_e;
endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] active_i,
  input  logic [LANES-1:0] taken_i,
  output br_class_e        cls_o,
  output logic [LANES-1:0] t_mask_o,
  output logic [LANES-1:0] nt_mask_o
);
  always_comb begin
    t_mask_o  = active_i & taken_i;
    nt_mask_o = active_i & ~taken_i;
    if (nt_mask_o == '0)      cls_o = BC_ALL_TAKEN;
    else if (t_mask_o == '0)  cls_o = BC_NONE_TAKEN;
    else                      cls_o = BC_SPLIT;
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             take_i,
  input  logic             pop_i,
  input  logic [PC_W-1:0]  rc_i,
  input  logic [PC_W-1:0]  fl_i,
  input  logic [LANES-1:0] pm_i,
  input  logic [LANES-1:0] om_i,
  output logic [PC_W-1:0]  rc_o,
  output logic [PC_W-1:0]  fl_o,
  output logic [LANES-1:0] pm_o,
  output logic [LANES-1:0] om_o,
  output logic             pend_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0]  sp_q, sp_d;
  logic [PC_W-1:0]  rc_all [DEPTH];
  logic [PC_W-1:0]  fl_all [DEPTH];
  logic [LANES-1:0] pm_all [DEPTH];
  logic [LANES-1:0] om_all [DEPTH];
  logic [DEPTH-1:0] pend_all;
  logic [IDX_W-1:0] top_idx;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign top_idx = empty_o ? '0 : IDX_W'(sp_q - 1'b1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [PC_W-1:0]  rc_q, fl_q;
    logic [LANES-1:0] pm_q, om_q;
    logic             pend_q;
    logic             wr_en, clr_en;

    assign wr_en  = push_i && (sp_q == SP_W'(g));
    assign clr_en = take_i && (sp_q == SP_W'(g + 1));

    always_ff @(posedge clk) begin
      if (wr_en) begin
        rc_q <= rc_i;
        fl_q <= fl_i;
        pm_q <= pm_i;
        om_q <= om_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (wr_en)  pend_q <= 1'b1;
      else if (clr_en) pend_q <= 1'b0;
    end

    assign rc_all[g]   = rc_q;
    assign fl_all[g]   = fl_q;
    assign pm_all[g]   = pm_q;
    assign om_all[g]   = om_q;
    assign pend_all[g] = pend_q;
  end

  assign rc_o   = rc_all[top_idx];
  assign fl_o   = fl_all[top_idx];
  assign pm_o   = pm_all[top_idx];
  assign om_o   = om_all[top_idx];
  assign pend_o = pend_all[top_idx] & ~empty_o;

  always_comb begin
    sp_d = sp_q;
    if (push_i && !full_o)      sp_d = sp_q + 1'b1;
    else if (pop_i && !empty_o) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target_pc,
  input  logic [PC_W-1:0]  br_fall_pc,
  input  logic [PC_W-1:0]  br_reconv_pc,
  input  logic             path_done,
  output logic [LANES-1:0] active_mask,
  output logic [PC_W-1:0]  next_pc,
  output logic             diverged,
  output logic [CNT_W-1:0] div_count,
  output logic             ovf_err
);
  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [LANES-1:0] mask_q, mask_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_q, div_d, ovf_q, ovf_d;
  logic             upd_en;

  br_class_e        cls;
  logic [LANES-1:0] t_mask, nt_mask;

  logic             push, take, pop;
  logic [PC_W-1:0]  top_rc, top_fl;
  logic [LANES-1:0] top_pm, top_om;
  logic             top_pend, stk_empty, stk_full;

  simt_branch_eval #(.LANES(LANES)) u_eval (
    .active_i  (mask_q),
    .taken_i   (br_taken),
    .cls_o     (cls),
    .t_mask_o  (t_mask),
    .nt_mask_o (nt_mask)
  );

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .push_i  (push),
    .take_i  (take),
    .pop_i   (pop),
    .rc_i    (br_reconv_pc),
    .fl_i    (br_fall_pc),
    .pm_i    (nt_mask),
    .om_i    (mask_q),
    .rc_o    (top_rc),
    .fl_o    (top_fl),
    .pm_o    (top_pm),
    .om_o    (top_om),
    .pend_o  (top_pend),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  // next-state logic: a branch outranks path-done
  always_comb begin
    mask_d = mask_q;
    pc_d   = pc_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    div_d  = 1'b0;
    push   = 1'b0;
    take   = 1'b0;
    pop    = 1'b0;
    if (br_valid) begin
      unique case (cls)
        BC_ALL_TAKEN:  pc_d = br_target_pc;
        BC_NONE_TAKEN: pc_d = br_fall_pc;
        default: begin
          if (stk_full) begin
            ovf_d = 1'b1;
          end else begin
            push   = 1'b1;
            mask_d = t_mask;
            pc_d   = br_target_pc;
            div_d  = 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
        end
      endcase
    end else if (path_done && !stk_empty) begin
      if (top_pend) begin
        take   = 1'b1;
        mask_d = top_pm;
        pc_d   = top_fl;
      end else begin
        pop    = 1'b1;
        mask_d = top_om;
        pc_d   = top_rc;
      end
    end
  end

  assign upd_en = br_valid | path_done;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mask_q <= '1;
      pc_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      div_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      if (upd_en) begin
        mask_q <= mask_d;
        pc_q   <= pc_d;
        cnt_q  <= cnt_d;
        ovf_q  <= ovf_d;
      end
    end
  end

  assign active_mask = mask_q;
  assign next_pc     = pc_q;
  assign div_count   = cnt_q;
  assign diverged    = div_q;
  assign ovf_err     = ovf_q;
endmodule

// File: rtl/simt_mask_ctrl_chk.sv
module simt_mask_ctrl_chk #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [LANES-1:0] br_taken,
  input logic             path_done,
  input logic [LANES-1:0] active_mask,
  input logic [PC_W-1:0]  next_pc,
  input logic             diverged,
  input logic [CNT_W-1:0] div_count,
  input logic             ovf_err
);
  // R4: some lane is always enabled
  assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

  // R2 / R3: an agreeing branch never changes the mask or flags divergence
  assert_uniform_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && (((active_mask & ~br_taken) == '0) || ((active_mask & br_taken) == '0))
    |=> (active_mask == $past(active_mask)) && !diverged);

  // R4: each divergence pulse advances the count by exactly one
  assert_div_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    diverged |-> (div_count - $past(div_count)) == CNT_W'(1));

  // R4: the taken-side mask is a subset of the mask before it
  assert_div_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    diverged |-> (active_mask & ~$past(active_mask)) == '0);

  // R8: the overflow flag is sticky
  assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R9: with no event the mask and PC hold
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid && !path_done |=> $stable(active_mask) && $stable(next_pc));
endmodule

bind simt_mask_ctrl simt_mask_ctrl_chk #(.LANES(LANES), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_valid    (br_valid),
  .br_taken    (br_taken),
  .path_done   (path_done),
  .active_mask (active_mask),
  .next_pc     (next_pc),
  .diverged    (diverged),
  .div_count   (div_count),
  .ovf_err     (ovf_err)
);

// File: tb/simt_mask_ctrl_tb.sv
`timescale 1ns/1ps
module simt_mask_ctrl_tb;
  localparam int LANES = 32;
  localparam int PC_W  = 32;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_taken = '0;
  logic [PC_W-1:0]  br_target_pc = '0;
  logic [PC_W-1:0]  br_fall_pc = '0;
  logic [PC_W-1:0]  br_reconv_pc = '0;
  logic             path_done = 1'b0;
  logic [LANES-1:0] active_mask;
  logic [PC_W-1:0]  next_pc;
  logic             diverged;
  logic [CNT_W-1:0] div_count;
  logic             ovf_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  simt_mask_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc), .br_reconv_pc(br_reconv_pc),
    .path_done(path_done), .active_mask(active_mask), .next_pc(next_pc),
    .diverged(diverged), .div_count(div_count), .ovf_err(ovf_err)
  );

  // behavioural reference model
  typedef struct {
    logic [PC_W-1:0]  rc;
    logic [PC_W-1:0]  fl;
    logic [LANES-1:0] pm;
    logic [LANES-1:0] om;
    bit               pend;
  } ent_t;

  ent_t             stk[$];
  logic [LANES-1:0] m_mask;
  logic [PC_W-1:0]  m_pc;
  logic [CNT_W-1:0] m_cnt;
  bit               m_div, m_ovf;
  int               m_since_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk.delete();
      m_mask = '1; m_pc = '0; m_cnt = '0; m_div = 0; m_ovf = 0; m_since_rst = 0;
    end else if (m_since_rst < 2) begin
      m_since_rst++;
    end else begin
      logic [LANES-1:0] tk, nt;
      ent_t e;
      m_div = 0;
      tk = m_mask & br_taken;
      nt = m_mask & ~br_taken;
      if (br_valid) begin
        if (nt == '0) m_pc = br_target_pc;
        else if (tk == '0) m_pc = br_fall_pc;
        else if (stk.size() >= DEPTH) m_ovf = 1;
        else begin
          e.rc = br_reconv_pc; e.fl = br_fall_pc; e.pm = nt; e.om = m_mask; e.pend = 1;
          stk.push_back(e);
          m_mask = tk; m_pc = br_target_pc; m_div = 1; m_cnt = m_cnt + 1'b1;
        end
      end else if (path_done && stk.size() > 0) begin
        e = stk[stk.size()-1];
        if (e.pend) begin
          stk[stk.size()-1].pend = 0;
          m_mask = e.pm; m_pc = e.fl;
        end else begin
          void'(stk.pop_back());
          m_mask = e.om; m_pc = e.rc;
        end
      end
    end
  end

  // model comparison on every falling edge (R2..R11, nesting order R7)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (active_mask !== m_mask || next_pc !== m_pc || diverged !== m_div ||
          div_count !== m_cnt || ovf_err !== m_ovf) begin
        errors++;
        $display("FAIL model R7/R11: mask=%h pc=%h div=%0d cnt=%0d ovf=%0d exp mask=%h pc=%h div=%0d cnt=%0d ovf=%0d",
                 active_mask, next_pc, diverged, div_count, ovf_err,
                 m_mask, m_pc, m_div, m_cnt, m_ovf);
      end
    end
  end

  task automatic chk(input string tag, input logic [LANES-1:0] em, input logic [PC_W-1:0] ep,
                     input logic [CNT_W-1:0] ec, input bit eo);
    checks++;
    if (active_mask !== em || next_pc !== ep || div_count !== ec || ovf_err !== eo) begin
      errors++;
      $display("FAIL %s: mask=%h pc=%h cnt=%0d ovf=%0d exp mask=%h pc=%h cnt=%0d ovf=%0d",
               tag, active_mask, next_pc, div_count, ovf_err, em, ep, ec, eo);
    end
  endtask

  task automatic chk_div(input string tag, input bit ed);
    checks++;
    if (diverged !== ed) begin
      errors++;
      $display("FAIL %s: diverged=%0d exp %0d", tag, diverged, ed);
    end
  endtask

  // drive one event for one cycle; outputs are valid at the next falling edge
  task automatic branch(input logic [LANES-1:0] tk, input logic [PC_W-1:0] tgt,
                        input logic [PC_W-1:0] fl, input logic [PC_W-1:0] rc, input bit pd);
    @(negedge clk);
    br_valid = 1'b1; br_taken = tk; br_target_pc = tgt; br_fall_pc = fl;
    br_reconv_pc = rc; path_done = pd;
    @(negedge clk);
    br_valid = 1'b0; path_done = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    path_done = 1'b1;
    @(negedge clk);
    path_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d exp below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [LANES-1:0] cur;
    logic [31:0] lfsr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset", '1, '0, '0, 0);
    chk_div("R1 reset", 0);

    branch(32'hFFFFFFFF, 32'h100, 32'h104, 32'h108, 0);
    chk("R2 all taken", '1, 32'h100, 0, 0);
    chk_div("R2 no pulse", 0);
    branch(32'h0, 32'h200, 32'h204, 32'h208, 0);
    chk("R3 none taken", '1, 32'h204, 0, 0);

    branch(32'h0000FFFF, 32'h300, 32'h304, 32'h400, 0);
    chk("R4 split", 32'h0000FFFF, 32'h300, 1, 0);
    chk_div("R4 pulse", 1);
    @(negedge clk);
    chk_div("R4 pulse one cycle", 0);
    branch(32'h000000FF, 32'h500, 32'h504, 32'h600, 0);
    chk("R4 nested split", 32'h000000FF, 32'h500, 2, 0);
    branch(32'hFFFFFF00, 32'h700, 32'h704, 32'h708, 0);
    chk("R3 inactive bits ignored", 32'h000000FF, 32'h704, 2, 0);

    done(); chk("R5 second side", 32'h0000FF00, 32'h504, 2, 0);
    done(); chk("R6 inner rejoin", 32'h0000FFFF, 32'h600, 2, 0);
    done(); chk("R5 outer second side", 32'hFFFF0000, 32'h304, 2, 0);
    done(); chk("R7 outer rejoin", '1, 32'h400, 2, 0);
    done(); chk("R9 done on empty", '1, 32'h400, 2, 0);
    repeat (3) @(negedge clk);
    chk("R9 idle", '1, 32'h400, 2, 0);

    branch(32'h0000000F, 32'h800, 32'h804, 32'h900, 0);
    branch(32'h00000003, 32'hA00, 32'hA04, 32'hB00, 1);
    chk("R10 branch wins", 32'h00000003, 32'hA00, 4, 0);
    done(); chk("R10 pending kept", 32'h0000000C, 32'hA04, 4, 0);
    done(); chk("R10 rejoin", 32'h0000000F, 32'hB00, 4, 0);
    done(); done();
    chk("R6 unwind", '1, 32'h900, 4, 0);

    // fill all eight levels, then one more
    cur = '1;
    for (int i = 0; i < DEPTH; i++) begin
      logic [LANES-1:0] nx;
      nx = cur & ~(cur & (~cur + 1'b1));
      branch(nx, 32'h2000 + 32'(i) * 16, 32'h2004 + 32'(i) * 16, 32'h3000 + 32'(i) * 16, 0);
      cur = nx;
    end
    chk("R7 depth eight", cur, 32'h2070, 12, 0);
    branch(cur & ~(cur & (~cur + 1'b1)), 32'h5000, 32'h5004, 32'h5008, 0);
    chk("R8 overflow refused", cur, 32'h2070, 12, 1);
    chk_div("R8 no pulse", 0);
    for (int i = 0; i < 2 * DEPTH; i++) done();
    chk("R7 LIFO unwind", '1, 32'h3000, 12, 1);
    chk("R8 sticky", '1, 32'h3000, 12, 1);

    // pseudo-random phase, model compared each cycle
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      br_valid = (lfsr[3:0] < 4'd5);
      br_taken = (lfsr[4]) ? {lfsr[15:0], lfsr[31:16]} : (lfsr[5] ? '1 : '0);
      br_target_pc = {16'h0, lfsr[31:16]};
      br_fall_pc   = {16'h1, lfsr[15:0]};
      br_reconv_pc = {16'h2, lfsr[23:8]};
      path_done = (lfsr[9:7] > 3'd2);
    end
    @(negedge clk);
    br_valid = 1'b0; path_done = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule